// File: doc/BRIEF.md
# Clock Post-Divider Output Channel

This block forms one output channel of a multi-source clock generator. It picks one of five incoming clocks (two references and three PLL outputs), divides the chosen clock by a ratio taken from a fixed sixteen-entry table, and produces a single clock for an output pad. A separate enable output tells the pad driver whether to drive or float the pin.

The divide ratios are not a plain binary count. The table includes odd ratios up to 25 and a top ratio of 50. Odd ratios reach a 50% duty cycle by combining a counter on the rising edge with a copy of its output retimed on the falling edge. Ratio 1 bypasses the counter entirely.

Two source codes are reserved and one code is a dedicated shutdown code. All three hold the output low. A stop input also forces the output low. All control inputs are static levels from a register bank, and they are plain pins with no handshake. A change to the source or the ratio may glitch the output. The new ratio is adopted at the next counter wrap.

Top module: `post_div_channel`

## Requirements
- R1: The source code `src_sel` selects the input clock as follows: 0 selects reference A, 1 selects reference B, 2 selects PLL A, 3 selects PLL B and 4 selects PLL C. The output period is the divide ratio times the period of the selected clock.
- R2: The modulus code `mod_code` values 0 to 15 select, in ascending order, the divide ratios 1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25 and 50.
- R3: For an even ratio N, the output is high for exactly N/2 cycles of the selected clock in each period.
- R4: For an odd ratio N greater than 1, the output is high for N/2 selected-clock cycles, a whole number of cycles plus one half. This gives a 50% duty cycle.
- R5: Ratio 1 (code 0) passes the selected clock to the output with its own period and duty cycle. With all controls at zero, the output is reference A undivided.
- R6: Source codes 5, 6 and 7 shut the channel down. The output stays low for as long as such a code is applied.
- R7: While `stop_low` is 1, the output is held low. When it returns to 0, the divided clock resumes.
- R8: `out_en` is 1 when `hiz_req` is 0 and 0 when `hiz_req` is 1. The clock output is unaffected.
- R9: A new modulus code takes effect only when the counter wraps. The period in progress finishes at the old ratio, and the next period uses the new ratio starting from count zero.
- R10: While `rst_n` is low, the output is held low. The divider restarts from count zero at ratio 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a_clk | input | 1 | Reference clock A (source code 0) |
| ref_b_clk | input | 1 | Reference clock B (source code 1) |
| pll_a_clk | input | 1 | PLL A clock (source code 2) |
| pll_b_clk | input | 1 | PLL B clock (source code 3) |
| pll_c_clk | input | 1 | PLL C clock (source code 4) |
| src_sel | input | 3 | Source select; codes 5 to 7 shut the channel down |
| mod_code | input | 4 | Index into the divide-ratio table |
| stop_low | input | 1 | 1 forces the output low |
| hiz_req | input | 1 | 1 requests that the pad float |
| clk_out | output | 1 | Divided output clock |
| out_en | output | 1 | Pad driver enable, active high |

## Verification
The properties assume that reference A runs continuously. They use it as a free-running sampling clock for the checks of the stop and shutdown paths. They also assume that the control inputs change only between clock edges and never at the same instant as an edge. The stimulus generates every source clock as an ideal square wave with an integer or half-integer period in nanoseconds. It changes the controls only at times offset from those edges, and it waits longer than the longest possible period before measuring. As a result, any glitch caused by a control change settles before an edge-to-edge measurement begins.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;
  localparam int NSRC    = 5;
  localparam int SEL_W   = 3;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 6;

  typedef enum logic [SEL_W-1:0] {
    SRC_REF_A = 3'd0,
    SRC_REF_B = 3'd1,
    SRC_PLL_A = 3'd2,
    SRC_PLL_B = 3'd3,
    SRC_PLL_C = 3'd4,
    SRC_RSV5  = 3'd5,
    SRC_RSV6  = 3'd6,
    SRC_OFF   = 3'd7
  } src_code_e;

  // Non-contiguous divide-ratio table, indexed by modulus code
  function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
    logic [RATIO_W-1:0] r;
    case (c)
      4'd0:    r = 6'd1;
      4'd1:    r = 6'd2;
      4'd2:    r = 6'd3;
      4'd3:    r = 6'd4;
      4'd4:    r = 6'd5;
      4'd5:    r = 6'd6;
      4'd6:    r = 6'd8;
      4'd7:    r = 6'd9;
      4'd8:    r = 6'd10;
      4'd9:    r = 6'd12;
      4'd10:   r = 6'd15;
      4'd11:   r = 6'd16;
      4'd12:   r = 6'd18;
      4'd13:   r = 6'd20;
      4'd14:   r = 6'd25;
      default: r = 6'd50;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pdc_src_mux.sv
`timescale 1ns/1ps
module pdc_src_mux #(
  parameter int NSRC  = pdc_pkg::NSRC,
  parameter int SEL_W = pdc_pkg::SEL_W
) (
  input  logic [NSRC-1:0]  srcs,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_clk,
  output logic             shut
);
  logic [NSRC-1:0] hit;

  // AND-OR clock selection; unassigned codes select nothing
  for (genvar i = 0; i < NSRC; i++) begin : g_leg
    assign hit[i] = (sel == SEL_W'(i)) & srcs[i];
  end

  assign sel_clk = |hit;
  assign shut    = (sel >= SEL_W'(NSRC));
endmodule

// File: rtl/pdc_ratio_dec.sv
`timescale 1ns/1ps
module pdc_ratio_dec #(
  parameter int CODE_W  = pdc_pkg::CODE_W,
  parameter int RATIO_W = pdc_pkg::RATIO_W
) (
  input  logic [CODE_W-1:0]  code,
  output logic [RATIO_W-1:0] ratio
);
  always_comb ratio = pdc_pkg::code_ratio(code);
endmodule

// File: rtl/pdc_div_core.sv
`timescale 1ns/1ps
module pdc_div_core #(
  parameter int RATIO_W = pdc_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               div_out
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] ratio_q, cnt_q, cnt_nxt, ratio_use, hi_len;
  logic               wrap, pos_q, neg_q, bypass, odd;

  // Ratio is adopted only at the wrap point
  always_comb begin
    wrap      = (cnt_q == ratio_q - ONE);
    ratio_use = wrap ? ratio_in : ratio_q;
    cnt_nxt   = wrap ? '0 : cnt_q + ONE;
    hi_len    = (ratio_use + ONE) >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      pos_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      ratio_q <= ratio_use;
      pos_q   <= (cnt_nxt < hi_len);
    end
  end

  // Half-cycle retimed copy used to trim odd ratios to 50% duty
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign bypass  = (ratio_q == ONE);
  assign odd     = ratio_q[0];
  assign div_out = bypass ? clk : (odd ? (pos_q & neg_q) : pos_q);
endmodule

// File: rtl/post_div_channel.sv
`timescale 1ns/1ps
module post_div_channel
  import pdc_pkg::*;
(
  input  logic              rst_n,
  input  logic              ref_a_clk,
  input  logic              ref_b_clk,
  input  logic              pll_a_clk,
  input  logic              pll_b_clk,
  input  logic              pll_c_clk,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [CODE_W-1:0] mod_code,
  input  logic              stop_low,
  input  logic              hiz_req,
  output logic              clk_out,
  output logic              out_en
);
  logic [NSRC-1:0]    srcs;
  logic               sel_clk, shut, div_out;
  logic [RATIO_W-1:0] ratio;

  assign srcs = {pll_c_clk, pll_b_clk, pll_a_clk, ref_b_clk, ref_a_clk};

  pdc_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .srcs    (srcs),
    .sel     (src_sel),
    .sel_clk (sel_clk),
    .shut    (shut)
  );

  pdc_ratio_dec #(.CODE_W(CODE_W), .RATIO_W(RATIO_W)) u_dec (
    .code  (mod_code),
    .ratio (ratio)
  );

  pdc_div_core #(.RATIO_W(RATIO_W)) u_core (
    .clk      (sel_clk),
    .rst_n    (rst_n),
    .ratio_in (ratio),
    .div_out  (div_out)
  );

  assign clk_out = rst_n & ~stop_low & ~shut & div_out;
  assign out_en  = ~hiz_req;
endmodule

// File: rtl/post_div_channel_chk.sv
`timescale 1ns/1ps
module post_div_channel_chk #(
  parameter int RATIO_W = pdc_pkg::RATIO_W,
  parameter int SEL_W   = pdc_pkg::SEL_W
) (
  input logic               rst_n,
  input logic               chk_clk,
  input logic               sclk,
  input logic               stop_low,
  input logic [SEL_W-1:0]   src_sel,
  input logic               clk_out,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] ratio_q,
  input logic               pos
);
  // R2: the count never reaches the active ratio
  p_cnt_range_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    cnt < ratio_q);

  // R9: the active ratio changes only at a restart from zero
  p_load_on_wrap_r9: assert property (@(posedge sclk) disable iff (!rst_n)
    (ratio_q != $past(ratio_q)) |-> (cnt == '0));

  // R3: every period starts with the shaped output high
  p_wrap_pos_high_r3: assert property (@(posedge sclk) disable iff (!rst_n)
    (cnt == '0) |-> pos);

  // R7: stop holds the pin low
  p_stop_low_r7: assert property (@(posedge chk_clk) disable iff (!rst_n)
    stop_low |-> !clk_out);

  // R6: shutdown and reserved codes hold the pin low
  p_shut_low_r6: assert property (@(posedge chk_clk) disable iff (!rst_n)
    (src_sel >= SEL_W'(5)) |-> !clk_out);
endmodule

bind post_div_channel post_div_channel_chk u_chk (
  .rst_n    (rst_n),
  .chk_clk  (ref_a_clk),
  .sclk     (sel_clk),
  .stop_low (stop_low),
  .src_sel  (src_sel),
  .clk_out  (clk_out),
  .cnt      (u_core.cnt_q),
  .ratio_q  (u_core.ratio_q),
  .pos      (u_core.pos_q)
);

// File: tb/post_div_channel_tb.sv
`timescale 1ns/1ps
module post_div_channel_tb;
  logic       clk = 0, ref_b = 0, pll_a = 0, pll_b = 0, pll_c = 0;
  logic       rst_n = 0, stop_low = 0, hiz_req = 0;
  logic [2:0] src_sel = 0;
  logic [3:0] mod_code = 0;
  logic       clk_out, out_en;

  always #2.5 clk   = ~clk;   // reference A, 200 MHz
  always #4   ref_b = ~ref_b;
  always #2   pll_a = ~pll_a;
  always #3   pll_b = ~pll_b;
  always #1.5 pll_c = ~pll_c;

  post_div_channel u_dut (
    .rst_n(rst_n), .ref_a_clk(clk), .ref_b_clk(ref_b), .pll_a_clk(pll_a),
    .pll_b_clk(pll_b), .pll_c_clk(pll_c), .src_sel(src_sel), .mod_code(mod_code),
    .stop_low(stop_low), .hiz_req(hiz_req), .clk_out(clk_out), .out_en(out_en)
  );

  int  total = 0, bad = 0;
  int  rtab [16] = '{1, 2, 3, 4, 5, 6, 8, 9, 10, 12, 15, 16, 18, 20, 25, 50};
  real sper [5]  = '{5.0, 8.0, 4.0, 6.0, 3.0};

  typedef struct { real per; real hi; string tag; } exp_t;
  exp_t sb [$];
  event mon_done;

  task automatic note(input bit ok, input string tag, input string what,
                      input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0.3f expected=%0.3f", tag, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  // Monitor: measure one full output period per queued expectation
  initial begin
    realtime t0, t1, t2;
    exp_t e;
    forever begin
      wait (sb.size() > 0);
      @(posedge clk_out) t0 = $realtime;
      @(negedge clk_out) t1 = $realtime;
      @(posedge clk_out) t2 = $realtime;
      e = sb.pop_front();
      note(near(t2 - t0, e.per), e.tag, "period", t2 - t0, e.per);
      note(near(t1 - t0, e.hi),  e.tag, "high",   t1 - t0, e.hi);
      -> mon_done;
    end
  end

  // Driver: apply controls, settle, queue the expected waveform
  task automatic drive_wave(input logic [2:0] s, input logic [3:0] c, input string tag);
    exp_t e;
    src_sel  = s;
    mod_code = c;
    #450.3;
    e.per = rtab[c] * sper[s];
    e.hi  = e.per / 2.0;
    e.tag = tag;
    sb.push_back(e);
    @(mon_done);
  endtask

  task automatic expect_low(input string tag, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      #1.3;
      if (clk_out !== 1'b0) highs++;
    end
    note(highs == 0, tag, "high samples", highs, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    realtime t0, t1, t2;
    // R10: output held low in reset, R8: pad enabled by default
    #0.7;
    expect_low("R10 in reset", 10);
    note(out_en === 1'b1, "R8 default", "out_en", out_en, 1);
    rst_n = 1;

    // R5: all-zero controls give undivided reference A
    drive_wave(3'd0, 4'd0, "R5 default pass-through");

    // R1: each source at ratio 3
    for (int s = 0; s < 5; s++)
      drive_wave(3'(s), 4'd2, "R1 source select");

    // R2 with R3/R4: every modulus code on PLL C
    for (int c = 0; c < 16; c++) begin
      if (rtab[c] == 1)       drive_wave(3'd4, 4'(c), "R2 R5 ratio 1");
      else if (rtab[c] % 2)   drive_wave(3'd4, 4'(c), "R2 R4 odd ratio");
      else                    drive_wave(3'd4, 4'(c), "R2 R3 even ratio");
    end
    drive_wave(3'd1, 4'd14, "R4 ratio 25 on ref B");

    // R6: shutdown and reserved source codes
    for (int s = 5; s < 8; s++) begin
      src_sel = 3'(s);
      #3.1;
      expect_low("R6 shutdown code", 60);
    end
    drive_wave(3'd0, 4'd1, "R6 recovery");

    // R7: stop bit
    stop_low = 1;
    #1.1;
    expect_low("R7 stopped", 60);
    stop_low = 0;
    drive_wave(3'd0, 4'd1, "R7 resume");

    // R8: tri-state request toggles only the enable
    hiz_req = 1;
    #1.1;
    note(out_en === 1'b0, "R8 hiz", "out_en", out_en, 0);
    drive_wave(3'd0, 4'd1, "R8 clock unaffected");
    hiz_req = 0;
    #1.1;
    note(out_en === 1'b1, "R8 release", "out_en", out_en, 1);

    // R9: modulus change mid-period completes the old period first
    src_sel = 3'd0; mod_code = 4'd15;
    #600.3;
    @(posedge clk_out) t0 = $realtime;
    #20.3 mod_code = 4'd3;
    @(posedge clk_out) t1 = $realtime;
    @(posedge clk_out) t2 = $realtime;
    note(near(t1 - t0, 250.0), "R9 old period", "period", t1 - t0, 250.0);
    note(near(t2 - t1, 20.0),  "R9 new period", "period", t2 - t1, 20.0);

    // R10: reset during operation
    #7.3 rst_n = 0;
    expect_low("R10 mid-run reset", 20);
    rst_n = 1;
    drive_wave(3'd0, 4'd3, "R10 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule